// File: doc/BRIEF.md
# Cache Line Refill Burst Sequencer

This block orders the word fetches that refill one cache line from external memory over a memory-mapped bus that supports bursts. A miss request carries the byte address that missed, a line-size code and a side select. The block then puts one read request on the bus and holds it until the bus accepts it. Each returned data beat is tagged with its word address and its word index inside the line. One cycle after the last beat, a single-cycle completion pulse marks the end of the refill.

Instruction-side refills fetch the missing word first. The order then climbs to the top of the line and wraps back to word 0. Data-side refills always start at the line base and climb. A one-word line never bursts. When bursting is switched off, a longer line is fetched as a chain of single-word requests, in the same order a burst would have used.

Top module: `refill_burst_seq`

## Requirements
- R1: During and after reset, with no miss pending, `busy`, `bus_req`, `beat_valid` and `done` are all 0.
- R2: Once raised, `bus_req` stays 1 with `bus_addr` and `bus_len` unchanged until the cycle in which `bus_ack` is 1.
- R3: With `instr_side`=1, the first beat is the word holding the missed address. Each later beat is the next word up, and the order wraps from the last word of the line to word 0. Example: a miss at 0x08 in a 32-byte line gives 0x08,0x0C,0x10,0x14,0x18,0x1C,0x00,0x04.
- R4: With `instr_side`=0, beats always start at the line-aligned address and ascend by 4, whatever the missed word was.
- R5: `line_sel` codes: 2'b01 is a 16-byte line and 2'b10 is a 32-byte line. With `burst_en`=1, these issue one request with `bus_len` 4 or 8 respectively, and `bus_addr` equal to the first beat's address.
- R6: `line_sel` 2'b00, and the unused code 2'b11, both mean a 4-byte line. Such a line issues exactly one request with `bus_len`=1 and gets exactly one beat.
- R7: `beat_valid` is 1 only in a cycle where `rdata_valid` is 1 while data is expected. Beat address and index advance only on such beats, so any number of wait cycles simply stall the sequence.
- R8: `done` is 1 for exactly one cycle, in the cycle after the last beat, and `busy` is 0 in the cycle after that.
- R9: A `miss_valid` that arrives while a refill is in progress is ignored, and the ongoing beat sequence is unchanged.
- R10: With `burst_en`=0 and a line longer than one word, each word gets its own request with `bus_len`=1, in the order R3/R4 give.
- R11: `beat_idx` is the word offset within the line of the beat's address, that is `beat_addr[4:2]` masked to the line size, and `beat_addr[1:0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request strobe, taken only when idle |
| miss_addr | input | ADDR_W | Byte address that missed |
| line_sel | input | 2 | Line-size code (00/11: 4 B, 01: 16 B, 10: 32 B) |
| instr_side | input | 1 | 1: critical word first with wrap; 0: line-aligned ascending |
| burst_en | input | 1 | 1: one burst per line; 0: single-word requests |
| bus_req | output | 1 | Read request to the bus |
| bus_addr | output | ADDR_W | Start address of the current request |
| bus_len | output | LEN_W | Beats in the current request |
| bus_ack | input | 1 | Bus accepts the request |
| rdata_valid | input | 1 | A read-data beat is present |
| beat_valid | output | 1 | The current data beat is tagged |
| beat_addr | output | ADDR_W | Word address of the current beat |
| beat_idx | output | OFS_W | Word index of the current beat in the line |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | A refill is in progress |

## Verification
The hardest case to reach is a burst-disabled, critical-word-first refill in which wait states land both between requests and between beats, while a stray miss arrives in the middle. The bench drives many refills with random line sizes, sides, burst enables and word offsets. It adds random acceptance delays, random data stalls and random stray misses during stalls, so these cases interleave often. It checks every beat against an order computed from the requirements. Directed cases pin down the wrap example, aligned data fills, the one-word line and the unused size code.

// File: rtl/refill_pkg.sv
package refill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } refill_state_e;

  localparam logic [1:0] LS_WORD = 2'b00;
  localparam logic [1:0] LS_QUAD = 2'b01;
  localparam logic [1:0] LS_OCT  = 2'b10;
endpackage

// File: rtl/refill_geom.sv
module refill_geom
  import refill_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MID_WORDS = 4,
  parameter int MAX_WORDS = 8,
  localparam int OFS_W    = $clog2(MAX_WORDS)
) (
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [1:0]        line_sel,
  input  logic              instr_side,
  output logic [OFS_W-1:0]  mask,
  output logic [ADDR_W-1:0] base,
  output logic [OFS_W-1:0]  start_ofs
);
  logic [ADDR_W-1:0] byte_mask;

  // line size code to word-offset mask
  always_comb begin
    case (line_sel)
      LS_QUAD: mask = OFS_W'(MID_WORDS - 1);
      LS_OCT:  mask = OFS_W'(MAX_WORDS - 1);
      default: mask = '0;
    endcase
  end

  assign byte_mask = {{(ADDR_W-OFS_W-2){1'b0}}, mask, 2'b11};
  assign base      = miss_addr & ~byte_mask;
  assign start_ofs = instr_side ? (miss_addr[OFS_W+1:2] & mask) : '0;
endmodule

// File: rtl/refill_addr_gen.sv
module refill_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int MAX_WORDS = 8,
  localparam int OFS_W    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [OFS_W-1:0]  mask_in,
  input  logic [OFS_W-1:0]  start_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [OFS_W-1:0]  cur_ofs,
  output logic [OFS_W-1:0]  mask_q,
  output logic              last
);
  logic [ADDR_W-1:0] base_q;
  logic [OFS_W-1:0]  ofs_q, cnt_q;
  logic [OFS_W-1:0]  ofs_nxt, cnt_nxt;

  always_comb begin
    ofs_nxt = ofs_q;
    cnt_nxt = cnt_q;
    if (adv) begin
      ofs_nxt = (ofs_q + 1'b1) & mask_q;
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
      ofs_q  <= '0;
      cnt_q  <= '0;
    end else if (load) begin
      base_q <= base_in;
      mask_q <= mask_in;
      ofs_q  <= start_in;
      cnt_q  <= '0;
    end else if (adv) begin
      ofs_q  <= ofs_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  assign cur_ofs  = ofs_q;
  assign cur_addr = base_q | {{(ADDR_W-OFS_W-2){1'b0}}, ofs_q, 2'b00};
  assign last     = (cnt_q == mask_q);
endmodule

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic miss_valid,
  input  logic single_in,
  input  logic bus_ack,
  input  logic rdata_valid,
  input  logic last_beat,
  output logic load,
  output logic adv,
  output logic bus_req,
  output logic beat_valid,
  output logic done,
  output logic busy,
  output logic single_q
);
  refill_state_e state_q, state_nxt;

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE: if (miss_valid) state_nxt = ST_REQ;
      ST_REQ:  if (bus_ack) state_nxt = ST_DATA;
      ST_DATA: begin
        if (rdata_valid) begin
          if (last_beat)     state_nxt = ST_DONE;
          else if (single_q) state_nxt = ST_REQ;
          else               state_nxt = ST_DATA;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      single_q <= 1'b0;
    end else begin
      state_q <= state_nxt;
      if (load) single_q <= single_in;
    end
  end

  assign load       = (state_q == ST_IDLE) && miss_valid;
  assign adv        = (state_q == ST_DATA) && rdata_valid;
  assign beat_valid = adv;
  assign bus_req    = (state_q == ST_REQ);
  assign done       = (state_q == ST_DONE);
  assign busy       = (state_q != ST_IDLE);
endmodule

// File: rtl/refill_burst_seq.sv
module refill_burst_seq #(
  parameter int ADDR_W    = 32,
  parameter int MID_WORDS = 4,
  parameter int MAX_WORDS = 8,
  localparam int OFS_W    = $clog2(MAX_WORDS),
  localparam int LEN_W    = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [1:0]        line_sel,
  input  logic              instr_side,
  input  logic              burst_en,
  output logic              bus_req,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [LEN_W-1:0]  bus_len,
  input  logic              bus_ack,
  input  logic              rdata_valid,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [OFS_W-1:0]  beat_idx,
  output logic              done,
  output logic              busy
);
  logic [OFS_W-1:0]  g_mask, g_start, mask_q, cur_ofs;
  logic [ADDR_W-1:0] g_base, cur_addr;
  logic load, adv, last, single_in, single_q;

  refill_geom #(.ADDR_W(ADDR_W), .MID_WORDS(MID_WORDS), .MAX_WORDS(MAX_WORDS)) i_geom (
    .miss_addr (miss_addr),
    .line_sel  (line_sel),
    .instr_side(instr_side),
    .mask      (g_mask),
    .base      (g_base),
    .start_ofs (g_start)
  );

  // one-word line or bursting off: one request per word
  assign single_in = !burst_en || (g_mask == '0);

  refill_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_valid (miss_valid),
    .single_in  (single_in),
    .bus_ack    (bus_ack),
    .rdata_valid(rdata_valid),
    .last_beat  (last),
    .load       (load),
    .adv        (adv),
    .bus_req    (bus_req),
    .beat_valid (beat_valid),
    .done       (done),
    .busy       (busy),
    .single_q   (single_q)
  );

  refill_addr_gen #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) i_agen (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .adv     (adv),
    .base_in (g_base),
    .mask_in (g_mask),
    .start_in(g_start),
    .cur_addr(cur_addr),
    .cur_ofs (cur_ofs),
    .mask_q  (mask_q),
    .last    (last)
  );

  assign bus_addr  = cur_addr;
  assign bus_len   = single_q ? LEN_W'(1) : ({1'b0, mask_q} + LEN_W'(1));
  assign beat_addr = cur_addr;
  assign beat_idx  = cur_ofs;
endmodule

// File: rtl/refill_seq_chk.sv
module refill_seq_chk #(
  parameter int ADDR_W    = 32,
  parameter int MID_WORDS = 4,
  parameter int MAX_WORDS = 8,
  localparam int OFS_W    = $clog2(MAX_WORDS),
  localparam int LEN_W    = OFS_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [LEN_W-1:0]  bus_len,
  input logic              bus_ack,
  input logic              rdata_valid,
  input logic              beat_valid,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              done,
  input logic              busy
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !beat_valid && !done)); // R1

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_len))); // R2

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> (bus_len == LEN_W'(1) || bus_len == LEN_W'(MID_WORDS) || bus_len == LEN_W'(MAX_WORDS))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rdata_valid && !bus_ack) |=> $stable(beat_addr)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!bus_req && !beat_valid)); // R8

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_addr[1:0] == 2'b00)); // R11
endmodule

bind refill_burst_seq refill_seq_chk #(
  .ADDR_W(ADDR_W), .MID_WORDS(MID_WORDS), .MAX_WORDS(MAX_WORDS)
) i_refill_seq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_addr   (bus_addr),
  .bus_len    (bus_len),
  .bus_ack    (bus_ack),
  .rdata_valid(rdata_valid),
  .beat_valid (beat_valid),
  .beat_addr  (beat_addr),
  .done       (done),
  .busy       (busy)
);

// File: tb/test_refill_burst_seq.sv
module test_refill_burst_seq;
  logic        clk, rst_n;
  logic        miss_valid;
  logic [31:0] miss_addr;
  logic [1:0]  line_sel;
  logic        instr_side, burst_en;
  logic        bus_req;
  logic [31:0] bus_addr;
  logic [3:0]  bus_len;
  logic        bus_ack, rdata_valid;
  logic        beat_valid;
  logic [31:0] beat_addr;
  logic [2:0]  beat_idx;
  logic        done, busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  refill_burst_seq i_refill_burst_seq (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .line_sel(line_sel), .instr_side(instr_side), .burst_en(burst_en),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_len(bus_len), .bus_ack(bus_ack),
    .rdata_valid(rdata_valid), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_idx(beat_idx), .done(done), .busy(busy)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  function automatic int words_of(input logic [1:0] ls);
    return (ls == 2'b01) ? 4 : (ls == 2'b10) ? 8 : 1;
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic [1:0] ls,
                                           input logic ins, input int k);
    int nw = words_of(ls);
    logic [31:0] base = a & ~(32'(nw * 4) - 1);
    int st = ins ? int'((a >> 2) & 32'(nw - 1)) : 0;
    return base + 32'(((st + k) % nw) * 4);
  endfunction

  task automatic do_refill(input logic [31:0] a, input logic [1:0] ls, input logic ins,
                           input logic ben, input bit stray, input bit rnd_wait, input string tag);
    int nw = words_of(ls);
    int nreq = (ben && nw > 1) ? 1 : nw;
    int bpr  = (ben && nw > 1) ? nw : 1;
    int k = 0;
    @(negedge clk);
    miss_valid = 1; miss_addr = a; line_sel = ls; instr_side = ins; burst_en = ben;
    @(posedge clk);
    @(negedge clk);
    miss_valid = 0;
    for (int r = 0; r < nreq; r++) begin
      int waits = rnd_wait ? int'($urandom % 4) : 0;
      logic [31:0] ea = exp_addr(a, ls, ins, k);
      for (int w = 0; w < waits; w++) begin
        #1 chk(bus_req == 1 && bus_addr == ea, {tag, " R2 request held"}, bus_addr, ea);
        if (stray && w == 0) begin
          miss_valid = 1; miss_addr = $urandom; line_sel = 2'b10; instr_side = ~ins; // R9
        end
        @(posedge clk);
        @(negedge clk);
        miss_valid = 0;
      end
      bus_ack = 1;
      #1 chk(bus_req == 1 && bus_addr == ea, {tag, " R5 request address"}, bus_addr, ea);
      chk(bus_len == 4'(bpr), {tag, (bpr == 1) ? " R10 single length" : " R5 burst length"},
          32'(bus_len), 32'(bpr));
      @(posedge clk);
      @(negedge clk);
      bus_ack = 0;
      for (int b = 0; b < bpr; b++) begin
        int stalls = rnd_wait ? int'($urandom % 3) : 0;
        logic [31:0] eb = exp_addr(a, ls, ins, k);
        for (int s = 0; s < stalls; s++) begin
          #1 chk(beat_valid == 0, {tag, " R7 no beat while stalled"}, 32'(beat_valid), 0);
          if (stray && s == 0) begin
            miss_valid = 1; miss_addr = $urandom; burst_en = ~ben; // R9
          end
          @(posedge clk);
          @(negedge clk);
          miss_valid = 0;
        end
        rdata_valid = 1;
        #1 chk(beat_valid == 1 && beat_addr == eb,
               {tag, ins ? " R3 beat address" : " R4 beat address"}, beat_addr, eb);
        chk(32'(beat_idx) == ((eb >> 2) & 32'(nw - 1)), {tag, " R11 beat index"},
            32'(beat_idx), (eb >> 2) & 32'(nw - 1));
        @(posedge clk);
        @(negedge clk);
        rdata_valid = 0;
        k++;
      end
    end
    #1 chk(done == 1, {tag, (nw == 1) ? " R6 done after one beat" : " R8 done pulse"}, 32'(done), 1);
    @(posedge clk);
    @(negedge clk);
    #1 chk(done == 0 && busy == 0, {tag, " R8 single pulse then idle"}, {30'b0, done, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; miss_valid = 0; miss_addr = 0; line_sel = 0; instr_side = 0;
    burst_en = 1; bus_ack = 0; rdata_valid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && bus_req == 0 && done == 0 && beat_valid == 0, "R1 in reset",
        {28'b0, busy, bus_req, done, beat_valid}, 0);
    rst_n = 1;
    @(posedge clk);
    @(negedge clk);
    chk(busy == 0 && bus_req == 0 && done == 0 && beat_valid == 0, "R1 after reset",
        {28'b0, busy, bus_req, done, beat_valid}, 0);

    do_refill(32'h0000_1008, 2'b10, 1, 1, 0, 0, "dir wrap8");
    do_refill(32'h0000_2000, 2'b10, 1, 1, 0, 0, "dir ins first");
    do_refill(32'h0000_3008, 2'b10, 0, 1, 0, 0, "dir data aligned");
    do_refill(32'h0000_401C, 2'b01, 1, 1, 1, 1, "dir wrap4");
    do_refill(32'h0000_5014, 2'b00, 1, 1, 0, 1, "dir R6 word");
    do_refill(32'h0000_6018, 2'b11, 0, 1, 0, 0, "dir R6 code3");
    do_refill(32'h0000_7024, 2'b01, 1, 0, 1, 1, "dir R10 singles");
    do_refill(32'h0000_8014, 2'b10, 0, 0, 0, 1, "dir R10 data");

    for (int i = 0; i < 80; i++) begin
      do_refill($urandom & 32'hFFFF_FFFC, 2'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), 1, "rnd");
    end

    finished = 1;
    summary();
    $finish;
  end
endmodule